// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one I2C master transaction at byte level each time software writes a command. It drives a lower-level bus engine through a request/done handshake. The engine handles SCL timing and the bit shifting, and this block decides which operation comes next. A transaction issues a START, or a repeated START when the bus is still owned. It then sends one or two address bytes and moves the programmed number of data bytes. Transmit bytes come from a transmit FIFO, and received bytes go into a receive FIFO. Completion and fault conditions leave the block as single-cycle event pulses for an interrupt controller.

The byte count comes from a 16-bit length field that is latched when the command is accepted. A length of zero gives a quick transfer. That transfer ends on the acknowledged address, so it reports the address-acknowledged event and no data-done event. A command without the STOP flag leaves the bus owned, so a later command can chain onto it with a repeated START. Any fault aborts the transfer, sends STOP and returns the block to idle.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `eng_req`, `bus_held` and all five event outputs are 0.
- R2: While idle, a `cmd_wr` whose `cmd_flags` has bit 7 (START) set and exactly one of bit 5 (READ) and bit 4 (WRITE) set starts a transfer. A START command with both or neither direction bit set is ignored, and so is any command written while `busy` is 1.
- R3: Engine operation codes on `eng_op` are 0 START, 1 repeated START, 2 write byte, 3 read byte and 4 STOP. In 7-bit mode (`ten_bit`=0), the operation after START is a write of `tgt_addr[7:0]`, which is the address in bits 7:1 and the R/W flag in bit 0.
- R4: In 10-bit mode, two address writes follow START. The first is {5'b11110, `tgt_addr[10:9]`, `tgt_addr[0]`} and the second is `tgt_addr[8:1]`. Each must be acknowledged before the sequence goes on.
- R5: A NACK (`eng_ack_in`=0) on any address byte pulses `ev_addr_nack`. No data operation follows; the next operation is STOP and the block then goes idle.
- R6: In a write transfer, `xfer_len` bytes are popped from the transmit FIFO and sent in order as write operations. `ev_done` pulses once after the last one.
- R7: In a read transfer, `xfer_len` read operations are issued. `eng_ack_out` is 1 on every one except the last, where it is 0. Each received byte is pushed on `rx_push`/`rx_data` in order.
- R8: `ev_addr_ack` pulses once the final address byte is acknowledged. With `xfer_len`=0 the transfer ends there, with no data operation and no `ev_done`.
- R9: With cmd bit 6 (STOP) set, a STOP operation follows completion and `bus_held` returns to 0. Without it, `bus_held` stays 1 and the next transfer starts with a repeated START. A command with only the STOP bit sends one STOP while the bus is held and is ignored otherwise.
- R10: `arb_lost` or `bus_fault` during a transfer pulses `ev_arb_lost` or `ev_bus_err` respectively. No `ev_done` follows, a STOP is issued and the block returns to idle with the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_flags | input | 4 | Command bits 7:4: START, STOP, READ, WRITE |
| tgt_addr | input | 11 | Target address; bit 0 R/W, bits 7:1 7-bit address, bits 10:1 10-bit address |
| ten_bit | input | 1 | 10-bit address mode |
| xfer_len | input | LEN_W | Data byte count, latched on command accept |
| eng_req | output | 1 | Operation request to the bus engine, held until done |
| eng_op | output | 3 | Requested operation code |
| eng_byte | output | 8 | Byte to send for write operations |
| eng_ack_out | output | 1 | ACK (1) or NACK (0) to drive after a read byte |
| eng_done | input | 1 | Engine finished the current operation (one cycle) |
| eng_ack_in | input | 1 | Target acknowledged the written byte, valid with eng_done |
| eng_rx_byte | input | 8 | Received byte, valid with eng_done |
| arb_lost | input | 1 | Arbitration loss seen by the engine |
| bus_fault | input | 1 | Bus error seen by the engine |
| tx_valid | input | 1 | Transmit FIFO holds a byte |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_push | output | 1 | Push rx_data into the receive FIFO |
| rx_data | output | 8 | Received byte |
| ev_done | output | 1 | Data-done event pulse |
| ev_addr_ack | output | 1 | Address-acknowledged event pulse |
| ev_addr_nack | output | 1 | Address-NACK error pulse |
| ev_arb_lost | output | 1 | Arbitration-lost error pulse |
| ev_bus_err | output | 1 | Bus-error pulse |
| busy | output | 1 | A transfer or STOP is in progress |
| bus_held | output | 1 | The bus is owned (START sent, STOP not yet sent) |

## Verification
The bound checker checks several things on every cycle. Completion events never coincide, and any address NACK or fault is followed at once by a STOP request. A finished STOP always leaves the block idle with the bus released, and receive pushes and data-done pulses only follow a finished data operation of the right kind. The exact byte values belong to the bench's scenarios: both address layouts, the transmit byte order, the ACK/NACK pattern on reads and the received data order. So do the repeated START after a held bus, commands ignored while busy or malformed, and aborts injected in the middle of a transfer.

// File: rtl/i2c_xfer_seq_pkg.sv
// Package: shared operation codes and sequencer states for the transfer sequencer.
// Assumes: operation codes are decoded by the external bus engine as listed.
package i2c_xfer_seq_pkg;
    localparam int unsigned BYTE_W = 8;

    // Operations handed to the bus engine
    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } bus_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_FETCH,
        S_WR,
        S_RD,
        S_STOP
    } seq_state_e;
endpackage

// File: rtl/i2c_xfer_seq_addr.sv
// Module: builds the address byte for the current address phase.
// Assumes: tgt_addr and ten_bit stay stable for the whole transfer.
// 7-bit mode sends tgt_addr[7:0]; 10-bit mode sends a header byte then tgt_addr[8:1].
module i2c_xfer_seq_addr
    import i2c_xfer_seq_pkg::*;
(
    input  logic [10:0]       tgt_addr,
    input  logic              ten_bit,
    input  logic              phase_idx,
    output logic [BYTE_W-1:0] addr_byte,
    output logic              addr_last
);
    localparam logic [4:0] TEN_HDR = 5'b11110;

    // Select the byte for this address phase and flag the final one
    always_comb begin
        if (ten_bit) begin
            addr_byte = phase_idx ? tgt_addr[8:1] : {TEN_HDR, tgt_addr[10:9], tgt_addr[0]};
            addr_last = phase_idx;
        end else begin
            addr_byte = tgt_addr[7:0];
            addr_last = 1'b1;
        end
    end
endmodule

// File: rtl/i2c_xfer_seq_cnt.sv
// Module: remaining data byte counter.
// Assumes: load and dec are never asserted together; dec at zero is ignored.
module i2c_xfer_seq_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_last
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] remain_q;

    // Load on command accept, count down per finished data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec && (remain_q != '0)) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign is_zero = (remain_q == '0);
    assign is_last = (remain_q == ONE);
endmodule

// File: rtl/i2c_xfer_seq_ctrl.sv
// Module: transfer state machine driving the bus engine handshake.
// Assumes: eng_done is a one-cycle pulse answering the held eng_req;
// arb_lost/bus_fault are sampled in every active state except STOP.
module i2c_xfer_seq_ctrl
    import i2c_xfer_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:4]        cmd_flags,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              addr_last,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              eng_done,
    input  logic              eng_ack_in,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    input  logic              arb_lost,
    input  logic              bus_fault,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              phase_idx,
    output logic              cnt_load,
    output logic              cnt_dec,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_ack_out,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ev_done,
    output logic              ev_addr_ack,
    output logic              ev_addr_nack,
    output logic              ev_arb_lost,
    output logic              ev_bus_err,
    output logic              busy,
    output logic              bus_held
);
    seq_state_e        state_q;
    logic              held_q;
    logic              rd_q;
    logic              stop_q;
    logic              aidx_q;
    logic [BYTE_W-1:0] wbyte_q;
    logic              start_ok;
    logic              fault;
    logic              active;
    bus_op_e           op_c;

    // Decode a well-formed start command
    assign start_ok = cmd_flags[7] && (cmd_flags[5] ^ cmd_flags[4]);
    assign fault    = arb_lost || bus_fault;
    // States in which faults abort the transfer
    assign active   = (state_q != S_IDLE) && (state_q != S_STOP);

    // Main sequencer: state, latched command and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            held_q       <= 1'b0;
            rd_q         <= 1'b0;
            stop_q       <= 1'b0;
            aidx_q       <= 1'b0;
            wbyte_q      <= '0;
            rx_push      <= 1'b0;
            rx_data      <= '0;
            ev_done      <= 1'b0;
            ev_addr_ack  <= 1'b0;
            ev_addr_nack <= 1'b0;
            ev_arb_lost  <= 1'b0;
            ev_bus_err   <= 1'b0;
        end else begin
            rx_push      <= 1'b0;
            ev_done      <= 1'b0;
            ev_addr_ack  <= 1'b0;
            ev_addr_nack <= 1'b0;
            ev_arb_lost  <= 1'b0;
            ev_bus_err   <= 1'b0;
            if (state_q == S_IDLE) begin
                if (cmd_wr && start_ok) begin
                    rd_q    <= cmd_flags[5];
                    stop_q  <= cmd_flags[6];
                    state_q <= S_START;
                end else if (cmd_wr && cmd_flags[6] && !cmd_flags[7] && held_q) begin
                    state_q <= S_STOP;
                end
            end else if (state_q == S_STOP) begin
                if (eng_done) begin
                    held_q  <= 1'b0;
                    state_q <= S_IDLE;
                end
            end else if (fault) begin
                ev_arb_lost <= arb_lost;
                ev_bus_err  <= bus_fault;
                state_q     <= S_STOP;
            end else begin
                case (state_q)
                    S_START: if (eng_done) begin
                        held_q  <= 1'b1;
                        aidx_q  <= 1'b0;
                        state_q <= S_ADDR;
                    end
                    S_ADDR: if (eng_done) begin
                        if (!eng_ack_in) begin
                            ev_addr_nack <= 1'b1;
                            state_q      <= S_STOP;
                        end else if (!addr_last) begin
                            aidx_q <= 1'b1;
                        end else begin
                            ev_addr_ack <= 1'b1;
                            if (cnt_zero) state_q <= stop_q ? S_STOP : S_IDLE;
                            else          state_q <= rd_q ? S_RD : S_FETCH;
                        end
                    end
                    S_FETCH: if (tx_valid) begin
                        wbyte_q <= tx_data;
                        state_q <= S_WR;
                    end
                    S_WR: if (eng_done) begin
                        if (cnt_last) begin
                            ev_done <= 1'b1;
                            state_q <= stop_q ? S_STOP : S_IDLE;
                        end else begin
                            state_q <= S_FETCH;
                        end
                    end
                    S_RD: if (eng_done) begin
                        rx_push <= 1'b1;
                        rx_data <= eng_rx_byte;
                        if (cnt_last) begin
                            ev_done <= 1'b1;
                            state_q <= stop_q ? S_STOP : S_IDLE;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    // Operation presented to the engine in each requesting state
    always_comb begin
        case (state_q)
            S_START: op_c = held_q ? OP_RESTART : OP_START;
            S_RD:    op_c = OP_READ;
            S_STOP:  op_c = OP_STOP;
            default: op_c = OP_WRITE;
        endcase
    end

    // Engine handshake and FIFO strobes
    assign eng_req     = (state_q == S_START) || (state_q == S_ADDR) || (state_q == S_WR)
                      || (state_q == S_RD) || (state_q == S_STOP);
    assign eng_op      = op_c;
    assign eng_byte    = (state_q == S_ADDR) ? addr_byte :
                         (state_q == S_WR)   ? wbyte_q   : '0;
    assign eng_ack_out = (state_q == S_RD) && !cnt_last;
    assign tx_pop      = (state_q == S_FETCH) && tx_valid && !fault;
    assign cnt_load    = (state_q == S_IDLE) && cmd_wr && start_ok;
    assign cnt_dec     = active && !fault && eng_done && ((state_q == S_WR) || (state_q == S_RD));
    assign phase_idx   = aidx_q;
    assign busy        = (state_q != S_IDLE);
    assign bus_held    = held_q;
endmodule

// File: rtl/i2c_xfer_seq.sv
// Module: top of the I2C master transfer sequencer; wires address builder,
// byte counter and state machine.
// Assumes: tgt_addr/ten_bit held stable during a transfer; xfer_len valid with cmd_wr.
module i2c_xfer_seq #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:4]       cmd_flags,
    input  logic [10:0]      tgt_addr,
    input  logic             ten_bit,
    input  logic [LEN_W-1:0] xfer_len,
    output logic             eng_req,
    output logic [2:0]       eng_op,
    output logic [7:0]       eng_byte,
    output logic             eng_ack_out,
    input  logic             eng_done,
    input  logic             eng_ack_in,
    input  logic [7:0]       eng_rx_byte,
    input  logic             arb_lost,
    input  logic             bus_fault,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             ev_done,
    output logic             ev_addr_ack,
    output logic             ev_addr_nack,
    output logic             ev_arb_lost,
    output logic             ev_bus_err,
    output logic             busy,
    output logic             bus_held
);
    logic       phase_idx;
    logic [7:0] addr_byte;
    logic       addr_last;
    logic       cnt_load;
    logic       cnt_dec;
    logic       cnt_zero;
    logic       cnt_last;

    i2c_xfer_seq_addr u_addr (
        .tgt_addr  (tgt_addr),
        .ten_bit   (ten_bit),
        .phase_idx (phase_idx),
        .addr_byte (addr_byte),
        .addr_last (addr_last)
    );

    i2c_xfer_seq_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (xfer_len),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero),
        .is_last  (cnt_last)
    );

    i2c_xfer_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_flags    (cmd_flags),
        .addr_byte    (addr_byte),
        .addr_last    (addr_last),
        .cnt_zero     (cnt_zero),
        .cnt_last     (cnt_last),
        .eng_done     (eng_done),
        .eng_ack_in   (eng_ack_in),
        .eng_rx_byte  (eng_rx_byte),
        .arb_lost     (arb_lost),
        .bus_fault    (bus_fault),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .phase_idx    (phase_idx),
        .cnt_load     (cnt_load),
        .cnt_dec      (cnt_dec),
        .eng_req      (eng_req),
        .eng_op       (eng_op),
        .eng_byte     (eng_byte),
        .eng_ack_out  (eng_ack_out),
        .tx_pop       (tx_pop),
        .rx_push      (rx_push),
        .rx_data      (rx_data),
        .ev_done      (ev_done),
        .ev_addr_ack  (ev_addr_ack),
        .ev_addr_nack (ev_addr_nack),
        .ev_arb_lost  (ev_arb_lost),
        .ev_bus_err   (ev_bus_err),
        .busy         (busy),
        .bus_held     (bus_held)
    );
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
// Module: protocol checker bound to the transfer sequencer.
// Assumes: operation codes 2 write, 3 read, 4 STOP.
module i2c_xfer_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_req,
    input logic [2:0] eng_op,
    input logic       eng_done,
    input logic       busy,
    input logic       bus_held,
    input logic       rx_push,
    input logic       ev_done,
    input logic       ev_addr_ack,
    input logic       ev_addr_nack,
    input logic       ev_arb_lost,
    input logic       ev_bus_err
);
    AST_EV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_done, ev_addr_ack, ev_addr_nack})); // R8
    AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_nack |-> (eng_req && eng_op == 3'd4)); // R5
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_arb_lost || ev_bus_err) |-> (eng_req && eng_op == 3'd4)); // R10
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 3'd4 && eng_done) |=> (!busy && !bus_held)); // R9
    AST_PUSH_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ($past(eng_done) && $past(eng_op) == 3'd3)); // R7
    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> ($past(eng_done) && ($past(eng_op) == 3'd2 || $past(eng_op) == 3'd3))); // R6
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (.*);

// File: tb/sim_i2c_xfer_seq.sv
module sim_i2c_xfer_seq;
    localparam int LEN_W = 16;
    localparam int LOGN  = 64;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [10:0] addr;
        logic        ten;
        logic [15:0] len;
        logic [7:0]  nack;
        logic [7:0]  ops;
        logic [2:0]  first;
        logic        aack;
        logic        done;
        logic        nk;
        logic        held;
    } vec_t;

    // cmd nibble: 8 START, 4 STOP, 2 READ, 1 WRITE; nack = op index answered with NACK
    localparam vec_t VECS [12] = '{
        '{4'hD, 11'h0A4, 1'b0, 16'd3, 8'hFF, 8'd6, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'hE, 11'h0A5, 1'b0, 16'd2, 8'hFF, 8'd5, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'hD, 11'h020, 1'b0, 16'd0, 8'hFF, 8'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'hD, 11'h5CC, 1'b1, 16'd1, 8'hFF, 8'd5, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'hD, 11'h0A4, 1'b0, 16'd4, 8'd1,  8'd3, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'hD, 11'h5CC, 1'b1, 16'd2, 8'd2,  8'd4, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'h9, 11'h0A4, 1'b0, 16'd2, 8'hFF, 8'd4, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{4'hE, 11'h0A5, 1'b0, 16'd1, 8'hFF, 8'd4, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'hB, 11'h0A4, 1'b0, 16'd2, 8'hFF, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h4, 11'h0A4, 1'b0, 16'd2, 8'hFF, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'hA, 11'h031, 1'b0, 16'd0, 8'hFF, 8'd2, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'h4, 11'h031, 1'b0, 16'd0, 8'hFF, 8'd1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [7:4]       cmd_flags = '0;
    logic [10:0]      tgt_addr = '0;
    logic             ten_bit = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             eng_req, eng_ack_out, tx_pop, rx_push, busy, bus_held;
    logic [2:0]       eng_op;
    logic [7:0]       eng_byte, rx_data;
    logic             eng_done = 1'b0, eng_ack_in = 1'b1;
    logic [7:0]       eng_rx_byte = '0;
    logic             arb_lost = 1'b0, bus_fault = 1'b0;
    logic             tx_valid = 1'b1;
    logic [7:0]       tx_data;
    logic             ev_done, ev_addr_ack, ev_addr_nack, ev_arb_lost, ev_bus_err;

    i2c_xfer_seq #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_flags(cmd_flags),
        .tgt_addr(tgt_addr), .ten_bit(ten_bit), .xfer_len(xfer_len),
        .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte), .eng_ack_out(eng_ack_out),
        .eng_done(eng_done), .eng_ack_in(eng_ack_in), .eng_rx_byte(eng_rx_byte),
        .arb_lost(arb_lost), .bus_fault(bus_fault), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .ev_done(ev_done),
        .ev_addr_ack(ev_addr_ack), .ev_addr_nack(ev_addr_nack), .ev_arb_lost(ev_arb_lost),
        .ev_bus_err(ev_bus_err), .busy(busy), .bus_held(bus_held)
    );

    // Bus engine model: answers each request after three cycles and logs it
    logic       log_clr = 1'b0;
    int         nack_at = -1;
    int         eng_cnt = 0;
    int         nlog = 0;
    logic [2:0] log_op   [LOGN];
    logic [7:0] log_byte [LOGN];
    logic       log_ack  [LOGN];
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n || log_clr) begin
            eng_cnt <= 0;
            nlog    <= 0;
        end else if (eng_req && !eng_done) begin
            if (eng_cnt == 2) begin
                eng_cnt     <= 0;
                eng_done    <= 1'b1;
                eng_ack_in  <= (nlog != nack_at);
                eng_rx_byte <= 8'hA0 + 8'(nlog);
                if (nlog < LOGN) begin
                    log_op[nlog]   <= eng_op;
                    log_byte[nlog] <= eng_byte;
                    log_ack[nlog]  <= eng_ack_out;
                end
                nlog <= nlog + 1;
            end else begin
                eng_cnt <= eng_cnt + 1;
            end
        end
    end

    // FIFO models and event counters
    int         tx_idx = 0, n_rx = 0;
    int         n_done = 0, n_aack = 0, n_nack = 0, n_arb = 0, n_berr = 0;
    logic [7:0] rx_log [LOGN];
    assign tx_data = 8'h50 + 8'(tx_idx);
    always @(posedge clk) begin
        if (!rst_n || log_clr) begin
            tx_idx <= 0; n_rx <= 0;
            n_done <= 0; n_aack <= 0; n_nack <= 0; n_arb <= 0; n_berr <= 0;
        end else begin
            if (tx_pop) tx_idx <= tx_idx + 1;
            if (rx_push) begin
                if (n_rx < LOGN) rx_log[n_rx] <= rx_data;
                n_rx <= n_rx + 1;
            end
            n_done <= n_done + int'(ev_done);
            n_aack <= n_aack + int'(ev_addr_ack);
            n_nack <= n_nack + int'(ev_addr_nack);
            n_arb  <= n_arb + int'(ev_arb_lost);
            n_berr <= n_berr + int'(ev_bus_err);
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [3:0] c, input logic [10:0] a, input logic t,
                             input logic [15:0] l, input int nk);
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr   = 1'b0;
        nack_at   = nk;
        tgt_addr  = a;
        ten_bit   = t;
        xfer_len  = l;
        cmd_flags = c;
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (busy) chk("watchdog busy", 1, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 req/held", int'({eng_req, bus_held}), 0);
        chk("R1 events", int'({ev_done, ev_addr_ack, ev_addr_nack, ev_arb_lost, ev_bus_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk
        for (int i = 0; i < 12; i++) begin
            vec_t v;
            v = VECS[i];
            start_cmd(v.cmd, v.addr, v.ten, v.len, (v.nack == 8'hFF) ? -1 : int'(v.nack));
            wait_idle();
            chk($sformatf("R2 vec%0d op count", i), nlog, int'(v.ops));
            if (v.ops != 0) chk($sformatf("R9 vec%0d first op", i), int'(log_op[0]), int'(v.first));
            chk($sformatf("R8 vec%0d addr-ack events", i), n_aack, int'(v.aack));
            chk($sformatf("R6 vec%0d done events", i), n_done, int'(v.done));
            chk($sformatf("R5 vec%0d nack events", i), n_nack, int'(v.nk));
            chk($sformatf("R9 vec%0d bus held", i), int'(bus_held), int'(v.held));
        end

        // R3 and R6: 7-bit address byte, then data bytes in FIFO order, then STOP
        start_cmd(4'hD, 11'h0B7, 1'b0, 16'd3, -1);
        wait_idle();
        chk("R3 addr op", int'(log_op[1]), 2);
        chk("R3 addr byte", int'(log_byte[1]), 8'hB7);
        for (int k = 0; k < 3; k++) begin
            chk($sformatf("R6 data op %0d", k), int'(log_op[2+k]), 2);
            chk($sformatf("R6 data byte %0d", k), int'(log_byte[2+k]), 8'h50 + k);
        end
        chk("R9 stop op", int'(log_op[5]), 4);

        // R4: 10-bit address bytes
        start_cmd(4'hD, 11'h5CD, 1'b1, 16'd1, -1);
        wait_idle();
        chk("R4 header byte", int'(log_byte[1]), int'({5'b11110, 2'b10, 1'b1}));
        chk("R4 low byte", int'(log_byte[2]), int'(8'hE6));
        chk("R4 data follows", int'(log_byte[3]), 8'h50);

        // R7: read ACK pattern and received data order
        start_cmd(4'hE, 11'h0A5, 1'b0, 16'd3, -1);
        wait_idle();
        chk("R7 rx count", n_rx, 3);
        for (int k = 0; k < 3; k++) begin
            chk($sformatf("R7 read op %0d", k), int'(log_op[2+k]), 3);
            chk($sformatf("R7 ack out %0d", k), int'(log_ack[2+k]), (k < 2) ? 1 : 0);
            chk($sformatf("R7 rx byte %0d", k), int'(rx_log[k]), 8'hA2 + k);
        end

        // R2: command while busy is ignored
        start_cmd(4'hD, 11'h0A4, 1'b0, 16'd4, -1);
        repeat (5) @(negedge clk);
        cmd_flags = 4'hE; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        wait_idle();
        chk("R2 busy cmd op count", nlog, 7);
        chk("R2 busy cmd no reads", n_rx, 0);

        // R10: arbitration loss in the middle of a write
        start_cmd(4'hD, 11'h0A4, 1'b0, 16'd8, -1);
        for (int n = 0; n < 500 && nlog < 3; n++) @(negedge clk);
        arb_lost = 1'b1;
        @(negedge clk);
        arb_lost = 1'b0;
        wait_idle();
        chk("R10 arb event", n_arb, 1);
        chk("R10 arb no done", n_done, 0);
        chk("R10 arb last op stop", int'(log_op[nlog-1]), 4);
        chk("R10 arb released", int'(bus_held), 0);

        // R10: bus fault in the middle of a read
        start_cmd(4'hE, 11'h0A5, 1'b0, 16'd8, -1);
        for (int n = 0; n < 500 && nlog < 4; n++) @(negedge clk);
        bus_fault = 1'b1;
        @(negedge clk);
        bus_fault = 1'b0;
        wait_idle();
        chk("R10 fault event", n_berr, 1);
        chk("R10 fault no done", n_done, 0);
        chk("R10 fault last op stop", int'(log_op[nlog-1]), 4);
        chk("R10 fault idle", int'({busy, bus_held}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule